// File: doc/BRIEF.md
# External Bus Wait-State Generator

This block times accesses on an external bus whose address space is cut into eight areas. The top address bits of each request pick an area. Each area has its own configuration bits:

- a data width of 8 or 16 bits;
- an access length of two or three bus states;
- an enable for the wait-state logic.

A single 2-bit wait-mode field and a single wait count are shared by all areas. Together with the active-low WAIT input, they decide how many wait states a three-state access gets.

A requester pulses `start` for one clock with an address and a direction. The block then drives the address strobe, the read strobe and the upper and lower write strobes, one clock per bus state. It raises `done` in the final state. A new start is taken only while the block is idle.

The configuration is loaded all at once through `cfg_load`. The area's settings and the global mode and count are captured when an access begins. WAIT is sampled on the rising clock edge that ends the second state and, where the mode calls for it, on the edge that ends a wait state.

Top module: `ext_bus_waitgen`

## Requirements
- R1: In reset and while idle, `as_n`, `rd_n`, `uwr_n` and `lwr_n` are high and `done` is low. After reset, every area is 8-bit, three-state and wait-enabled, the mode field is 2'b11 and the count is 3. A read to any area therefore takes 6 states.
- R2: The area of an access is `addr[ADDR_W-1 -: 3]`. Configuration bit i of each per-area vector applies to area i.
- R3: An access to a two-state area lasts exactly 2 states, with `done` in the second. It never waits, whatever WAIT, the mode or the count are.
- R4: In an 8-bit area, only the upper write strobe `uwr_n` is used for writes, and `lwr_n` stays high for the whole access.
- R5: In a 16-bit area, an even address (addr[0]=0) uses `uwr_n` and an odd address uses `lwr_n`. The two write strobes are never low together.
- R6: `as_n` is low in every state of an access. `rd_n` is low in every state of a read. The selected write strobe is low from the second state through the last state of a write. `done` is a single-clock pulse in the last state.
- R7: With the mode field at 2'b00, a three-state access takes 3 states with no wait.
- R8: With the mode field at 2'b11 (programmable), a three-state access inserts exactly the count of wait states, whatever WAIT does.
- R9: With the mode field at 2'b10 (pin auto-wait), the count of wait states is inserted only if WAIT is low when sampled at the end of the second state. Otherwise no wait is inserted.
- R10: With the mode field at 2'b01 (pin wait), the count of wait states is inserted first. One more wait state is then added for each edge at which WAIT is sampled low at the end of the last wait state. With a count of 0, the first sample is taken at the end of the second state.
- R11: In a three-state area whose enable bit is clear, waits come from the WAIT pin alone. This behaves as pin wait with a count of 0, whatever the mode field and count are.
- R12: A `start` while an access is in progress is ignored. A configuration load during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one bus state per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Loads all configuration fields below |
| cfg_wide | input | 8 | Per-area width: 1 = 16-bit, 0 = 8-bit |
| cfg_three | input | 8 | Per-area length: 1 = three-state, 0 = two-state |
| cfg_wen | input | 8 | Per-area wait-logic enable |
| cfg_mode | input | 2 | Wait mode: 00 none, 01 pin, 10 pin auto, 11 programmable |
| cfg_cnt | input | 2 | Programmed wait count |
| start | input | 1 | Begins an access when idle |
| addr | input | 24 | Access address |
| we | input | 1 | 1 = write, 0 = read |
| wait_n | input | 1 | Active-low external WAIT |
| as_n | output | 1 | Address strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| uwr_n | output | 1 | Upper byte write strobe, active low |
| lwr_n | output | 1 | Lower byte write strobe, active low |
| done | output | 1 | Last state of the access |

## Verification
Four rules are checked on every cycle by assertions:

- a two-state access ends in its second state;
- narrow areas never touch the lower strobe, and the two write strobes never overlap;
- `done` is one clock wide and an access never stops early;
- the programmable and auto-wait modes insert exactly the allowed number of waits.

Other behaviours can only be shown by the bench's scenarios. These are the exact access length under each WAIT pattern, the pin-wait extension, the lane choice by address parity, the reset defaults, and the fact that a mid-access start or configuration load leaves the running access untouched.

// File: rtl/ext_bus_waitgen.sv
module ext_bus_waitgen #(
  parameter int ADDR_W = 24,
  parameter int AREAS  = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [AREAS-1:0]  cfg_wide,
  input  logic [AREAS-1:0]  cfg_three,
  input  logic [AREAS-1:0]  cfg_wen,
  input  logic [1:0]        cfg_mode,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              wait_n,
  output logic              as_n,
  output logic              rd_n,
  output logic              uwr_n,
  output logic              lwr_n,
  output logic              done
);
  localparam int AW = $clog2(AREAS);
  localparam logic [1:0] M_NONE = 2'b00, M_PIN = 2'b01, M_AUTO = 2'b10, M_PROG = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3} state_t;

  state_t            state;
  logic [AREAS-1:0]  wide_q, three_q, wen_q;
  logic [1:0]        mode_q, c_mode;
  logic [CNT_W-1:0]  cnt_q, c_cnt, rem;
  logic              c_three, c_wide, c_lo, c_we;
  logic [7:0]        waits;

  wire [AW-1:0] area = addr[ADDR_W-1 -: AW];
  wire          busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q  <= '0;
      three_q <= '1;
      wen_q   <= '1;
      mode_q  <= M_PROG;
      cnt_q   <= CNT_W'(3);
    end else if (cfg_load) begin
      wide_q  <= cfg_wide;
      three_q <= cfg_three;
      wen_q   <= cfg_wen;
      mode_q  <= cfg_mode;
      cnt_q   <= cfg_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rem     <= '0;
      c_three <= 1'b0;
      c_wide  <= 1'b0;
      c_lo    <= 1'b0;
      c_we    <= 1'b0;
      c_mode  <= M_NONE;
      c_cnt   <= '0;
      waits   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          c_three <= three_q[area];
          c_wide  <= wide_q[area];
          c_lo    <= wide_q[area] & addr[0];
          c_we    <= we;
          c_mode  <= wen_q[area] ? mode_q : M_PIN;
          c_cnt   <= wen_q[area] ? cnt_q : '0;
          waits   <= '0;
          state   <= S_T1;
        end
        S_T1: state <= S_T2;
        S_T2: begin
          if (!c_three) state <= S_IDLE;
          else begin
            unique case (c_mode)
              M_NONE: state <= S_T3;
              M_PROG: begin
                state <= (c_cnt != 0) ? S_TW : S_T3;
                rem   <= c_cnt;
              end
              M_AUTO: begin
                state <= (!wait_n && c_cnt != 0) ? S_TW : S_T3;
                rem   <= c_cnt;
              end
              M_PIN: begin
                state <= (c_cnt != 0 || !wait_n) ? S_TW : S_T3;
                rem   <= c_cnt;
              end
            endcase
          end
        end
        S_TW: begin
          waits <= waits + 8'd1;
          if (rem > 1) rem <= rem - 1'b1;
          else if (c_mode == M_PIN && !wait_n) rem <= '0;
          else state <= S_T3;
        end
        S_T3: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  wire wr_phase = c_we && (state == S_T2 || state == S_TW || state == S_T3);

  assign as_n  = !busy;
  assign rd_n  = !(busy && !c_we);
  assign uwr_n = !(wr_phase && !c_lo);
  assign lwr_n = !(wr_phase && c_lo);
  assign done  = (state == S_T2 && !c_three) || (state == S_T3);

  a_r3_two_state_short: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T1 && !c_three) |=> done);
  a_r4_narrow_lower_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !c_wide) |-> lwr_n);
  a_r5_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !(!uwr_n && !lwr_n));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r8_prog_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T3 && c_mode == M_PROG) |-> (waits == 8'(c_cnt)));
  a_r9_auto_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T3 && c_mode == M_AUTO) |-> (waits == 8'd0 || waits == 8'(c_cnt)));
endmodule

// File: tb/tb_ext_bus_waitgen.sv
module tb_ext_bus_waitgen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [7:0] cfg_wide = '0, cfg_three = '0, cfg_wen = '0;
  logic [1:0] cfg_mode = '0, cfg_cnt = '0;
  logic start = 1'b0, we = 1'b0, wait_n = 1'b1;
  logic [23:0] addr = '0;
  logic as_n, rd_n, uwr_n, lwr_n, done;

  int checks = 0, fails = 0;
  logic [7:0] m_wide, m_three, m_wen;
  logic [1:0] m_mode, m_cnt;

  ext_bus_waitgen dut (.*);

  always #10 clk = ~clk;

  initial begin
    #20_000_000;
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input bit three, input bit en, input logic [1:0] mode,
                                 input int cnt, input int low_till);
    int n, j;
    logic [1:0] md;
    if (!three) return 2;
    md = en ? mode : 2'b01;
    n  = en ? cnt : 0;
    case (md)
      2'b00: return 3;
      2'b11: return 3 + n;
      2'b10: return (2 <= low_till) ? 3 + n : 3;
      default: begin
        j = 2 + n;
        while (j <= low_till) begin n++; j = 2 + n; end
        return 3 + n;
      end
    endcase
  endfunction

  task automatic load_cfg(input logic [7:0] w, t, e, input logic [1:0] md, c);
    @(negedge clk);
    cfg_wide = w; cfg_three = t; cfg_wen = e; cfg_mode = md; cfg_cnt = c; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_wide = w; m_three = t; m_wen = e; m_mode = md; m_cnt = c;
  endtask

  task automatic access(input logic [23:0] a, input bit w, input int low_till,
                        input bit meddle, input string req);
    int ar, len, i, doneseen;
    bit up, lo, ok;
    ar  = a[23:21];
    len = exp_len(m_three[ar], m_wen[ar], m_mode, m_cnt, low_till);
    up  = !m_wide[ar] || !a[0];
    lo  = m_wide[ar] && a[0];
    @(negedge clk);
    addr = a; we = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    i = 1; ok = 1; doneseen = 0;
    while (1) begin
      wait_n = !(i <= low_till);
      if (meddle && i == 2) begin
        start = 1'b1; addr = ~a; cfg_load = 1'b1;
        cfg_three = '0; cfg_wen = '1; cfg_mode = 2'b00; cfg_wide = ~m_wide;
      end
      if (meddle && i == 3) begin start = 1'b0; cfg_load = 1'b0; end
      if (as_n !== 1'b0) ok = 0;
      if (rd_n !== (w ? 1'b1 : 1'b0)) ok = 0;
      if (uwr_n !== !(w && up && i >= 2)) ok = 0;
      if (lwr_n !== !(w && lo && i >= 2)) ok = 0;
      if (done === 1'b1) begin doneseen = i; break; end
      if (i > 40) break;
      @(negedge clk);
      i++;
    end
    chk(doneseen == len, {req, " length"}, doneseen, len);
    chk(ok, {req, " strobes R6"}, ok, 1);
    @(negedge clk);
    if (meddle) begin start = 1'b0; cfg_load = 1'b0; end
    wait_n = 1'b1;
    chk(as_n && rd_n && uwr_n && lwr_n && !done, {req, " idle after access R1"}, as_n, 1);
  endtask

  initial begin
    void'($urandom(32'd7321));
    m_wide = '0; m_three = '1; m_wen = '1; m_mode = 2'b11; m_cnt = 2'd3;
    #5;
    chk(as_n && rd_n && uwr_n && lwr_n && !done, "R1 reset outputs", done, 0);
    #50 rst_n = 1'b1;
    access(24'h000010, 1'b0, 0, 0, "R1 default read six states");
    access(24'hE00011, 1'b1, 5, 0, "R4 R8 default write narrow area");

    load_cfg(8'hF0, 8'h0F, 8'hFF, 2'b11, 2'd2);
    access(24'h800000, 1'b0, 6, 0, "R3 two-state ignores WAIT");
    access(24'h200000, 1'b0, 0, 0, "R2 area1 three-state prog");
    access(24'h800001, 1'b1, 0, 0, "R5 wide odd lower lane");
    access(24'hA00002, 1'b1, 0, 0, "R5 wide even upper lane");

    load_cfg(8'hFF, 8'hFF, 8'hFF, 2'b00, 2'd3);
    access(24'h400001, 1'b1, 6, 0, "R7 no-wait mode");

    load_cfg(8'hFF, 8'hFF, 8'hFF, 2'b10, 2'd2);
    access(24'h400000, 1'b0, 2, 0, "R9 auto WAIT low");
    access(24'h400000, 1'b0, 1, 0, "R9 auto WAIT high at sample");

    load_cfg(8'hFF, 8'hFF, 8'hFF, 2'b01, 2'd1);
    access(24'h600000, 1'b0, 6, 0, "R10 pin extension");
    access(24'h600000, 1'b0, 2, 0, "R10 pin count only");
    load_cfg(8'hFF, 8'hFF, 8'hFF, 2'b01, 2'd0);
    access(24'h600000, 1'b0, 3, 0, "R10 pin count zero");

    load_cfg(8'h00, 8'hFF, 8'hFE, 2'b11, 2'd3);
    access(24'h000000, 1'b0, 4, 0, "R11 enable clear pin-only");
    access(24'h000000, 1'b0, 0, 0, "R11 enable clear WAIT high");

    load_cfg(8'h00, 8'hFF, 8'hFF, 2'b11, 2'd3);
    access(24'h200004, 1'b0, 0, 1, "R12 start and load mid-access");
    m_three = '0; m_wen = '1; m_mode = 2'b00; m_wide = 8'hFF;
    access(24'h200004, 1'b1, 0, 0, "R12 load took effect afterwards");

    for (int k = 0; k < 300; k++) begin
      if (k % 20 == 0)
        load_cfg(8'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom));
      access(24'($urandom), 1'($urandom), int'($urandom_range(0, 6)), 0, "R2 R8 R9 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule